// File: doc/BRIEF.md
# FSK Caller-ID Bit Sequencer

This block turns a small set of length settings and a 64-byte message buffer into the serial bit stream of an on-hook FSK data message, such as a caller-ID burst. After a start request it sends three counted phases in a fixed order. The first is a run of alternating bits for line seizure. The second is a run of mark ('1') flag bits. The third is a series of message bytes, each framed with start and stop bits. One bit leaves on each pulse of a bit-clock enable, which is usually derived from the modem baud rate. An FSK modulator downstream turns the bits into tones.

A host writes the three lengths and a mark-after-send option through a narrow configuration port, and loads message bytes through a separate buffer write port. Any phase whose length is zero is skipped. The data length is clamped to the buffer depth. When the message ends the block raises a one-clock done pulse. After that it either keeps the line driven with continuous mark or releases it, depending on the mark-after-send option.

Top module: `fsk_bitseq`

## Requirements
- R1: With seizure length S (0 to 255), the seizure phase sends 2×S bits alternating 0,1,0,1,..., starting with 0.
- R2: With flag length F (0 to 255), F consecutive '1' bits follow the seizure phase.
- R3: Each message byte is framed as a '0' start bit, then eight data bits LSB first, then a '1' stop bit. Bytes come from buffer addresses 0, 1, 2, ... in that order.
- R4: A data length W above the buffer depth (64) is treated as exactly 64 bytes.
- R5: A phase whose length is 0 sends no bits and the next phase follows at once. With all lengths 0 a start yields no data bits, only the closing bit period.
- R6: `active` is high from the clock after an accepted start until the end. The end is the bit-enable that follows the last bit sent. At that bit-enable `done` is high for exactly one clock and `active` falls.
- R7: While `active` is low, `txBit` is '1'. At each bit-enable while idle, `lineOn` takes the mark-after-send setting. During a running message `lineOn` is '1' once bits flow.
- R8: A start pulse while `active` is high has no effect on the bit stream or its length.
- R9: After reset all three lengths and mark-after-send are 0, `txBit` is '1', and `lineOn`, `active` and `done` are 0.
- R10: Configuration writes use `cfgSel` to pick the target. 0 is the seizure length, 1 is the flag length, 2 is the data length, and 3 is mark-after-send, taken from bit 0 of `cfgData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | Bit-clock enable, one pulse per bit period |
| startPulse | input | 1 | Start request, accepted only while idle |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target select (see R10) |
| cfgData | input | LEN_W (8) | Configuration write value |
| bufWe | input | 1 | Message buffer write strobe |
| bufAddr | input | AW (6) | Message buffer write address |
| bufData | input | 8 | Message buffer write byte |
| txBit | output | 1 | Serial bit toward the modulator |
| lineOn | output | 1 | Line driven (bits or continuous mark) |
| active | output | 1 | Message in progress |
| done | output | 1 | One-clock pulse at message end |

## Verification
The embedded assertions watch several properties on every cycle. They check that `done` never lasts two clocks and never coincides with a running message. They check that the idle line stays at '1', that a start during a message leaves the phase state untouched, and that the seizure and byte counters stay inside their snapshot bounds. The bench's scenarios are needed for the ordering and content of the stream: the alternating seizure pattern, the flag run, LSB-first byte framing from successive buffer addresses, the clamp to 64 bytes, phase skipping at zero lengths, and the release or hold of the line after the message.

// File: rtl/fsk_seq_pkg.sv
package fsk_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEIZE,
    ST_FLAG,
    ST_DATA,
    ST_TAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_ONE,
    SRC_ZERO,
    SRC_DATA
  } bit_src_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     emit;     // update the output bit this cycle
    bit_src_e src;      // where the new bit comes from
    logic     running;  // bit belongs to a message in progress
  } seq_strobe_t;

  localparam logic [1:0] CFG_SEIZE = 2'd0;
  localparam logic [1:0] CFG_FLAG  = 2'd1;
  localparam logic [1:0] CFG_WORDS = 2'd2;
  localparam logic [1:0] CFG_MARK  = 2'd3;

  // start + 8 data + stop, positions 0..9
  localparam int FRAME_BITS = 10;

endpackage

// File: rtl/fsk_seq_dp.sv
module fsk_seq_dp
  import fsk_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [LEN_W-1:0] cfgData,
  input  logic             bufWe,
  input  logic [AW-1:0]    bufAddr,
  input  logic [7:0]       bufData,
  input  seq_strobe_t      strb,
  input  logic [AW-1:0]    byteAddr,
  input  logic [3:0]       bitPos,
  output logic [LEN_W-1:0] seizLen,
  output logic [LEN_W-1:0] flagLen,
  output logic [CNT_W-1:0] wordLen,
  output logic             txBit,
  output logic             lineOn
);

  logic [LEN_W-1:0] wordCfg;
  logic             markCfg;
  logic [7:0]       msgMem [DEPTH];
  logic [7:0]       curByte;
  logic [2:0]       dataIdx;
  logic [3:0]       posLess;

  // Length and option registers (R10, reset values R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seizLen <= '0;
      flagLen <= '0;
      wordCfg <= '0;
      markCfg <= 1'b0;
    end else if (cfgWe) begin
      case (cfgSel)
        CFG_SEIZE: seizLen <= cfgData;
        CFG_FLAG:  flagLen <= cfgData;
        CFG_WORDS: wordCfg <= cfgData;
        default:   markCfg <= cfgData[0];
      endcase
    end
  end

  // Clamp of the data length to the buffer depth (R4)
  always_comb begin
    if (int'(wordCfg) > DEPTH) wordLen = CNT_W'(DEPTH);
    else                       wordLen = CNT_W'(wordCfg);
  end

  // Message buffer, host-written
  always_ff @(posedge clk) begin
    if (bufWe) msgMem[bufAddr] <= bufData;
  end

  assign curByte = msgMem[byteAddr];
  assign posLess = bitPos - 4'd1;
  assign dataIdx = posLess[2:0];

  // Output bit and line enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit  <= 1'b1;
      lineOn <= 1'b0;
    end else if (strb.emit) begin
      case (strb.src)
        SRC_ZERO: txBit <= 1'b0;
        SRC_DATA: txBit <= curByte[dataIdx];
        default:  txBit <= 1'b1;
      endcase
      lineOn <= strb.running | markCfg;
    end
  end

  // Data bits only ever come from positions 1..8 of a frame (R3)
  p_data_pos_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && strb.src == SRC_DATA) |-> (bitPos >= 4'd1 && bitPos <= 4'd8));

endmodule

// File: rtl/fsk_seq_ctrl.sv
module fsk_seq_ctrl
  import fsk_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] seizLen,
  input  logic [LEN_W-1:0] flagLen,
  input  logic [CNT_W-1:0] wordLen,
  output seq_strobe_t      strb,
  output logic [AW-1:0]    byteAddr,
  output logic [3:0]       bitPos,
  output logic             active,
  output logic             done
);

  localparam logic [3:0] LAST_POS = 4'(FRAME_BITS - 1);

  seq_state_e       state;
  seq_state_e       firstState, afterSeize, afterFlag;
  logic [LEN_W:0]   cnt;
  logic [LEN_W:0]   seizBits;
  logic [LEN_W-1:0] flagBits;
  logic [CNT_W-1:0] byteLen;
  logic [CNT_W-1:0] byteCnt;
  logic             startOk;

  assign startOk  = startPulse && (state == ST_IDLE);
  assign active   = (state != ST_IDLE);
  assign byteAddr = byteCnt[AW-1:0];

  // Phase order with zero-length phases skipped (R5)
  always_comb begin
    if (seizLen != '0)      firstState = ST_SEIZE;
    else if (flagLen != '0) firstState = ST_FLAG;
    else if (wordLen != '0) firstState = ST_DATA;
    else                    firstState = ST_TAIL;

    if (flagBits != '0)     afterSeize = ST_FLAG;
    else if (byteLen != '0) afterSeize = ST_DATA;
    else                    afterSeize = ST_TAIL;

    if (byteLen != '0)      afterFlag = ST_DATA;
    else                    afterFlag = ST_TAIL;
  end

  // Strobes toward the datapath
  always_comb begin
    strb.emit    = bitEn;
    strb.src     = SRC_ONE;
    strb.running = 1'b0;
    case (state)
      ST_SEIZE: begin
        strb.running = 1'b1;
        strb.src     = cnt[0] ? SRC_ONE : SRC_ZERO;
      end
      ST_FLAG: begin
        strb.running = 1'b1;
        strb.src     = SRC_ONE;
      end
      ST_DATA: begin
        strb.running = 1'b1;
        if (bitPos == 4'd0)          strb.src = SRC_ZERO;
        else if (bitPos == LAST_POS) strb.src = SRC_ONE;
        else                         strb.src = SRC_DATA;
      end
      default: begin
        strb.running = 1'b0;
        strb.src     = SRC_ONE;
      end
    endcase
  end

  // Phase sequencing and counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      seizBits <= '0;
      flagBits <= '0;
      byteLen  <= '0;
      byteCnt  <= '0;
      bitPos   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (startOk) begin
        seizBits <= {seizLen, 1'b0};
        flagBits <= flagLen;
        byteLen  <= wordLen;
        cnt      <= '0;
        byteCnt  <= '0;
        bitPos   <= '0;
        state    <= firstState;
      end else if (bitEn) begin
        case (state)
          ST_SEIZE: begin
            if (cnt == seizBits - 1'b1) begin
              cnt   <= '0;
              state <= afterSeize;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_FLAG: begin
            if (cnt == {1'b0, flagBits} - 1'b1) begin
              cnt   <= '0;
              state <= afterFlag;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bitPos == LAST_POS) begin
              bitPos <= '0;
              if (byteCnt == byteLen - 1'b1) begin
                byteCnt <= '0;
                state   <= ST_TAIL;
              end else begin
                byteCnt <= byteCnt + 1'b1;
              end
            end else begin
              bitPos <= bitPos + 1'b1;
            end
          end
          ST_TAIL: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: done is a single-clock pulse and only appears once idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(startOk)) |-> (state == ST_IDLE));

  // R8: a start during a message leaves the phase state alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && state != ST_IDLE && !bitEn) |=> (state == $past(state)));

  // R1: seizure counter stays inside the doubled snapshot length
  p_seize_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEIZE) |-> (cnt < seizBits));

  // R4: byte index within clamped length, which never exceeds the depth
  p_byte_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (byteCnt < byteLen && int'(byteLen) <= DEPTH && bitPos <= LAST_POS));

endmodule

// File: rtl/fsk_bitseq.sv
module fsk_bitseq
  import fsk_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             startPulse,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [LEN_W-1:0] cfgData,
  input  logic             bufWe,
  input  logic [AW-1:0]    bufAddr,
  input  logic [7:0]       bufData,
  output logic             txBit,
  output logic             lineOn,
  output logic             active,
  output logic             done
);

  seq_strobe_t      strb;
  logic [AW-1:0]    byteAddr;
  logic [3:0]       bitPos;
  logic [LEN_W-1:0] seizLen;
  logic [LEN_W-1:0] flagLen;
  logic [CNT_W-1:0] wordLen;

  fsk_seq_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .startPulse (startPulse),
    .seizLen    (seizLen),
    .flagLen    (flagLen),
    .wordLen    (wordLen),
    .strb       (strb),
    .byteAddr   (byteAddr),
    .bitPos     (bitPos),
    .active     (active),
    .done       (done)
  );

  fsk_seq_dp #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .bufWe    (bufWe),
    .bufAddr  (bufAddr),
    .bufData  (bufData),
    .strb     (strb),
    .byteAddr (byteAddr),
    .bitPos   (bitPos),
    .seizLen  (seizLen),
    .flagLen  (flagLen),
    .wordLen  (wordLen),
    .txBit    (txBit),
    .lineOn   (lineOn)
  );

  // R7: an idle line always rests at '1'
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> txBit);

endmodule

// File: tb/fsk_bitseq_tb.sv
`timescale 1ns/1ps
module fsk_bitseq_tb;

  localparam int DEPTH = 64;
  localparam int LEN_W = 8;
  localparam int AW    = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             bitEn = 1'b0;
  logic             startPulse = 1'b0;
  logic             cfgWe = 1'b0;
  logic [1:0]       cfgSel = '0;
  logic [LEN_W-1:0] cfgData = '0;
  logic             bufWe = 1'b0;
  logic [AW-1:0]    bufAddr = '0;
  logic [7:0]       bufData = '0;
  logic             txBit, lineOn, active, done;

  fsk_bitseq #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .startPulse(startPulse),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData),
    .txBit(txBit), .lineOn(lineOn), .active(active), .done(done)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  logic [1:0] expQ[$];      // {isLast, bit}
  logic [7:0] shadow[DEPTH];
  int         checks = 0;
  int         errors = 0;
  string      curTag = "R9";
  bit         doneSeen = 1'b0;
  bit         startReq = 1'b0;
  bit         armed = 1'b0;
  int         bitIdx = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Pacing driver: bit enable every 4 clocks, start requests, all after the edge
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk); #1;
      phase++;
      bitEn      = (phase % 4 == 0);
      startPulse = startReq;
      startReq   = 1'b0;
    end
  end

  // Monitor: compares each bit produced by a running message
  initial begin
    forever begin
      @(negedge clk);
      if (armed) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s extra bit actual=%0d expected=%0d", curTag, txBit, 1);
        end else begin
          logic [1:0] item;
          item = expQ.pop_front();
          chk(txBit == item[0], curTag, $sformatf("bit %0d", bitIdx), txBit, item[0]);
          bitIdx++;
          if (item[1]) begin
            chk(done == 1'b1 && active == 1'b0, "R6", "done/active at end", {done, active}, 2);
            doneSeen = 1'b1;
          end else begin
            chk(done == 1'b0, "R6", "early done", done, 0);
          end
        end
      end
      armed = bitEn && active;
    end
  end

  task automatic writeCfg(logic [1:0] sel, int val);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgSel = sel; cfgData = LEN_W'(val);
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic loadBuf();
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = 8'((i * 37 + 11) & 255);
      @(posedge clk); #1;
      bufWe = 1'b1; bufAddr = AW'(i); bufData = shadow[i];
    end
    @(posedge clk); #1;
    bufWe = 1'b0;
  endtask

  // R10 encoding: sel 0 seizure, 1 flag, 2 data length, 3 mark option
  task automatic runSeq(int sl, int fl, int wl, bit mark, string tag, bit poke, bit skipCfg);
    int n;
    if (!skipCfg) begin
      writeCfg(2'd0, sl);
      writeCfg(2'd1, fl);
      writeCfg(2'd2, wl);
      writeCfg(2'd3, int'(mark));
    end
    n = (wl > DEPTH) ? DEPTH : wl;
    expQ.delete();
    for (int i = 0; i < sl; i++) begin
      expQ.push_back(2'b00);
      expQ.push_back(2'b01);
    end
    for (int i = 0; i < fl; i++) expQ.push_back(2'b01);
    for (int b = 0; b < n; b++) begin
      expQ.push_back(2'b00);
      for (int k = 0; k < 8; k++) expQ.push_back({1'b0, shadow[b][k]});
      expQ.push_back(2'b01);
    end
    expQ.push_back(2'b11);
    curTag   = tag;
    bitIdx   = 0;
    doneSeen = 1'b0;
    startReq = 1'b1;
    if (poke) begin
      repeat (60) @(negedge clk);
      startReq = 1'b1;            // R8: must be ignored
      repeat (20) @(negedge clk);
      startReq = 1'b1;
    end
    while (!doneSeen) @(negedge clk);
    chk(expQ.size() == 0, tag, "bits left over", expQ.size(), 0);
  endtask

  task automatic idleLine(bit expMark);
    do @(negedge clk); while (!bitEn);
    @(negedge clk);
    chk(lineOn == expMark, "R7", "lineOn idle", lineOn, expMark);
    chk(txBit == 1'b1, "R7", "txBit idle", txBit, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(txBit == 1'b1, "R9", "reset txBit", txBit, 1);
    chk(lineOn == 1'b0, "R9", "reset lineOn", lineOn, 0);
    chk(active == 1'b0, "R9", "reset active", active, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    @(posedge clk); #1 rstN = 1'b1;
    loadBuf();
    // R9: lengths reset to zero, so a start sends only the closing period
    runSeq(0, 0, 0, 1'b0, "R9", 1'b0, 1'b1);
    idleLine(1'b0);
    // R1 R2 R3: all three phases
    runSeq(2, 3, 2, 1'b0, "R1/R2/R3", 1'b0, 1'b0);
    idleLine(1'b0);
    // R5: seizure and flags skipped
    runSeq(0, 0, 1, 1'b0, "R5", 1'b0, 1'b0);
    // R5: flags and data skipped
    runSeq(3, 0, 0, 1'b0, "R5", 1'b0, 1'b0);
    // R5: everything skipped
    runSeq(0, 0, 0, 1'b0, "R5", 1'b0, 1'b0);
    // R4: clamp to 64 bytes, with R7 mark-after-send
    runSeq(0, 2, 200, 1'b1, "R4", 1'b0, 1'b0);
    idleLine(1'b1);
    writeCfg(2'd3, 0);
    idleLine(1'b0);
    // R1 maximum lengths, R8 start during a message
    runSeq(255, 255, 3, 1'b0, "R1/R8", 1'b1, 1'b0);
    idleLine(1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule